// File: doc/BRIEF.md
# Priority Maximum Extractor With Zeroing

This block sits between a maximum-candidate detector and the next search stage of a cascaded top-W selector. It receives a set of lanes, each holding an unsigned value, along with one flag per lane. The detector raises a flag on every lane that holds the current largest value. The extractor picks exactly one flagged lane: the one with the lowest index. It presents that lane's value as the current maximum. It also hands on a copy of the lane set in which the chosen lane is forced to zero, so that the following stage finds the next largest value.

The block is purely combinational and has no clock or state. Lane priority comes from a running "already taken" chain, built as a prefix OR of the flags. This chain yields a select vector with at most one bit set. Each lane is then gated by its select bit, and the gated lanes are merged with a per-bit OR tree to form the maximum. The lane set is packed as a flat bus, with lane `i` in bits `[i*WIDTH +: WIDTH]`.

Top module: `pmx_extract_top`

## Requirements
- R1: `pick_o[0]` equals `flag_i[0]`, whatever the other flags are.
- R2: For lane i ≥ 1, `pick_o[i]` is 1 exactly when `flag_i[i]` is 1 and no lower-index flag is set. The lowest flagged lane is therefore the one chosen.
- R3: `pick_o` never has more than one bit set. It has exactly one bit set whenever any flag is set.
- R4: `max_o` equals the value of the chosen lane. When several flagged lanes hold equal values, the value is the same whichever of them is chosen.
- R5: In `rest_o`, the chosen lane is all zeros and every other lane equals the matching lane of `cand_i`.
- R6: When `flag_i` is all zero, `pick_o` is zero, `max_o` is zero and `rest_o` equals `cand_i`.
- R7: When several flagged lanes hold the same value, only the lowest-index one is zeroed in `rest_o`. The others pass through unchanged.
- R8: Flags on lanes that are not the lowest flagged lane have no effect on `max_o` or on `rest_o`, even when those lanes hold larger values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cand_i | input | LANES*WIDTH | Packed candidate lanes, lane i at bits [i*WIDTH +: WIDTH] |
| flag_i | input | LANES | Maximum-candidate flag per lane, bit i for lane i |
| max_o | output | WIDTH | Value of the chosen lane, or zero when no flag is set |
| rest_o | output | LANES*WIDTH | Candidate lanes with the chosen lane replaced by zero |
| pick_o | output | LANES | One-hot select vector marking the chosen lane |

## Verification
The extraction of the maximum and the zeroing of that same lane in the forwarded set always happen together, from one select vector. The bench therefore provokes them at once with ties: equal values in several flagged lanes, in all flags set, and in a flagged lane whose value is zero. Each applied pattern is judged on three outputs together. `max_o` must equal the lowest flagged lane's value. `rest_o` must differ from `cand_i` in that lane only. `pick_o` must be that lane's single bit. A wrong priority, or zeroing more than one lane, shows up in at least one of the three comparisons.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
    parameter int unsigned PMX_LANES = 8;
    parameter int unsigned PMX_WIDTH = 8;
endpackage

// File: rtl/pmx_priority_chain.sv
module pmx_priority_chain #(
    parameter int unsigned LANES = pmx_pkg::PMX_LANES
) (
    input  logic [LANES-1:0] flag_i,
    output logic [LANES-1:0] pick_o
);
    // taken[i] says some lane 0..i carries a flag
    logic [LANES-2:0] taken;

    assign pick_o[0] = flag_i[0];
    assign taken[0]  = flag_i[0];

    for (genvar i = 1; i < LANES; i++) begin : g_chain
        assign pick_o[i] = flag_i[i] & ~taken[i-1];
        if (i < LANES - 1) begin : g_run
            assign taken[i] = taken[i-1] | flag_i[i];
        end
    end

    always_comb begin
        AST_PICK_ONEHOT: assert ($onehot0(pick_o)) else $error("pick not one-hot"); // R3
        AST_PICK_FLAGGED: assert ((pick_o & ~flag_i) == '0) else $error("pick on unflagged lane"); // R2
        AST_PICK_PRESENT: assert ((|flag_i) == (|pick_o)) else $error("flag without pick"); // R3
    end
endmodule

// File: rtl/pmx_lane_gate.sv
module pmx_lane_gate #(
    parameter int unsigned LANES = pmx_pkg::PMX_LANES,
    parameter int unsigned WIDTH = pmx_pkg::PMX_WIDTH,
    localparam int unsigned BUSW = LANES * WIDTH
) (
    input  logic [BUSW-1:0]  cand_i,
    input  logic [LANES-1:0] pick_i,
    output logic [BUSW-1:0]  gated_o,
    output logic [BUSW-1:0]  rest_o
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [WIDTH-1:0] lane;
        assign lane = cand_i[i*WIDTH +: WIDTH];
        assign gated_o[i*WIDTH +: WIDTH] = lane & {WIDTH{pick_i[i]}};
        assign rest_o[i*WIDTH +: WIDTH]  = lane & {WIDTH{~pick_i[i]}};

        always_comb begin
            AST_REST_CLEARED: assert (!pick_i[i] || rest_o[i*WIDTH +: WIDTH] == '0) else $error("chosen lane not cleared"); // R5
            AST_REST_KEPT: assert (pick_i[i] || rest_o[i*WIDTH +: WIDTH] == lane) else $error("other lane altered"); // R7
        end
    end
endmodule

// File: rtl/pmx_or_merge.sv
module pmx_or_merge #(
    parameter int unsigned LANES = pmx_pkg::PMX_LANES,
    parameter int unsigned WIDTH = pmx_pkg::PMX_WIDTH,
    localparam int unsigned BUSW = LANES * WIDTH
) (
    input  logic [BUSW-1:0]  gated_i,
    output logic [WIDTH-1:0] merged_o
);
    always_comb begin
        merged_o = '0;
        for (int i = 0; i < LANES; i++) begin
            merged_o = merged_o | gated_i[i*WIDTH +: WIDTH];
        end
    end
endmodule

// File: rtl/pmx_extract_top.sv
module pmx_extract_top #(
    parameter int unsigned LANES = pmx_pkg::PMX_LANES,
    parameter int unsigned WIDTH = pmx_pkg::PMX_WIDTH,
    localparam int unsigned BUSW = LANES * WIDTH
) (
    input  logic [BUSW-1:0]  cand_i,
    input  logic [LANES-1:0] flag_i,
    output logic [WIDTH-1:0] max_o,
    output logic [BUSW-1:0]  rest_o,
    output logic [LANES-1:0] pick_o
);
    logic [BUSW-1:0] gated;

    pmx_priority_chain #(.LANES(LANES)) u_chain (
        .flag_i (flag_i),
        .pick_o (pick_o)
    );

    pmx_lane_gate #(.LANES(LANES), .WIDTH(WIDTH)) u_gate (
        .cand_i  (cand_i),
        .pick_i  (pick_o),
        .gated_o (gated),
        .rest_o  (rest_o)
    );

    pmx_or_merge #(.LANES(LANES), .WIDTH(WIDTH)) u_merge (
        .gated_i  (gated),
        .merged_o (max_o)
    );

    always_comb begin
        AST_IDLE_MAX_ZERO: assert ((|flag_i) || max_o == '0) else $error("max without flag"); // R6
        AST_IDLE_PASS: assert ((|flag_i) || rest_o == cand_i) else $error("set altered without flag"); // R6
        AST_MAX_FROM_SET: assert ((rest_o | gated) == cand_i) else $error("lost lane bits"); // R4
    end
endmodule

// File: tb/pmx_extract_top_test.sv
module pmx_extract_top_test;
    localparam int unsigned LANES = 8;
    localparam int unsigned WIDTH = 8;
    localparam int unsigned BUSW  = LANES * WIDTH;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [BUSW-1:0]  cand = '0;
    logic [LANES-1:0] flag = '0;
    logic [WIDTH-1:0] max_w;
    logic [BUSW-1:0]  rest_w;
    logic [LANES-1:0] pick_w;

    pmx_extract_top #(.LANES(LANES), .WIDTH(WIDTH)) uut (
        .cand_i (cand),
        .flag_i (flag),
        .max_o  (max_w),
        .rest_o (rest_w),
        .pick_o (pick_w)
    );

    typedef struct {
        logic [WIDTH-1:0] mx;
        logic [BUSW-1:0]  rest;
        logic [LANES-1:0] pick;
        string            req;
    } exp_t;

    exp_t scb[$];
    int   total = 0;
    int   bad   = 0;
    bit   finished = 0;

    // Driver: computes the expected result from the requirements and queues it
    task automatic apply(input logic [BUSW-1:0] v, input logic [LANES-1:0] f, input string req);
        exp_t e;
        int   low;
        low = -1;
        for (int i = LANES - 1; i >= 0; i--) if (f[i]) low = i;
        e.req  = req;
        e.rest = v;
        e.mx   = '0;
        e.pick = '0;
        if (low >= 0) begin
            e.pick[low] = 1'b1;
            e.mx = v[low*WIDTH +: WIDTH];
            e.rest[low*WIDTH +: WIDTH] = '0;
        end
        @(posedge clk);
        #1;
        cand = v;
        flag = f;
        scb.push_back(e);
    endtask

    // Monitor: pops one expected item per cycle, mid-cycle
    always @(negedge clk) begin
        if (rst_n && scb.size() > 0) begin
            exp_t e;
            e = scb.pop_front();
            total += 3;
            if (max_w !== e.mx) begin
                bad++;
                $display("FAIL %s R4 max got %h exp %h", e.req, max_w, e.mx);
            end
            if (rest_w !== e.rest) begin
                bad++;
                $display("FAIL %s R5 rest got %h exp %h", e.req, rest_w, e.rest);
            end
            if (pick_w !== e.pick) begin
                bad++;
                $display("FAIL %s R2 pick got %b exp %b", e.req, pick_w, e.pick);
            end
        end
    end

    function automatic logic [BUSW-1:0] fill(input logic [WIDTH-1:0] a);
        logic [BUSW-1:0] r;
        for (int i = 0; i < LANES; i++) r[i*WIDTH +: WIDTH] = a + WIDTH'(i * 17);
        return r;
    endfunction

    initial begin
        logic [BUSW-1:0] v;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // reset state, no flags: R6
        apply('0, '0, "R6-reset");
        apply(fill(8'h31), '0, "R6-pass");
        // single flag at lane 0: R1
        apply(fill(8'h05), 8'b0000_0001, "R1-only0");
        apply(fill(8'h05), 8'b1010_0001, "R1-with-others");
        // single flags elsewhere: R2
        apply(fill(8'h40), 8'b0001_0000, "R2-lane4");
        apply(fill(8'h40), 8'b1000_0000, "R2-top");
        apply(fill(8'h09), 8'b0110_0100, "R2-lowest2");
        // all flags set: R3
        apply(fill(8'hA0), 8'hFF, "R3-all");
        // ties: equal values in flagged lanes, R7 and R4
        v = fill(8'h11);
        v[1*WIDTH +: WIDTH] = 8'hF0;
        v[3*WIDTH +: WIDTH] = 8'hF0;
        v[6*WIDTH +: WIDTH] = 8'hF0;
        apply(v, 8'b0100_1010, "R7-tie3");
        apply(v, 8'b0100_1000, "R7-tie2");
        // higher flagged lane holds a bigger value, ignored: R8
        v = fill(8'h02);
        v[2*WIDTH +: WIDTH] = 8'h10;
        v[5*WIDTH +: WIDTH] = 8'hFF;
        apply(v, 8'b0010_0100, "R8-ignored");
        // flagged lane holding zero: R4
        v = fill(8'h33);
        v[0] = 1'b0;
        v[0 +: WIDTH] = '0;
        apply(v, 8'b0000_0011, "R4-zero-val");
        // all-ones values, lane 7 only: R5
        apply({BUSW{1'b1}}, 8'b1000_0000, "R5-ones");
        // varied patterns: R2
        for (int k = 0; k < 40; k++) begin
            logic [LANES-1:0] fr;
            v  = {$urandom(), $urandom()};
            fr = LANES'($urandom());
            apply(v, fr, "R2-mix");
        end
        apply(fill(8'h77), '0, "R6-end");
        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule